// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block keeps the working copies of a device's protected configuration registers. A parallel input holds the default values that would come from non-volatile storage. On a hardware reset, and on a software reset command, the working copies are loaded from that input. The rest of the device reads only the working copies, on the `cfg_q` bus. A later change on the default input therefore has no effect until the next reload.

The host reaches the bank through a single-cycle write port and a combinational read port. A protected register accepts a host value only if the write that came just before it put the key value 0x35 into the shadow-control register at 0x3A. Any other write in between cancels that permission. An accepted value stays in place until the next reset.

Writing 0xA5 to the command register at 0x3C performs a software reset. It reloads every protected register from the defaults and clears the device address register. The device address register at 0x3B can be written at any time without the key.

Top module: `shadow_cfg_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, protected register i (address 0x40+i, byte i of `cfg_q`) loads byte i of `dflt_in`, the device address loads 0x00, and any unlock is cleared.
- R2: Outside reloads and accepted writes, `cfg_q` and `dev_addr` hold their values, whatever `dflt_in` does.
- R3: A write of 0x35 to address 0x3A arms the bank. If the very next write targets a protected address (0x40 to 0x40+NUM_PROT-1), that write updates the register at the same clock edge. Writing the key again while armed keeps the bank armed.
- R4: A write to a protected address while the bank is not armed leaves every protected register unchanged.
- R5: Any write other than the key write disarms the bank, including a write of a non-key value to 0x3A. A protected write also consumes the unlock. Only one protected write is accepted per key.
- R6: A write of 0xA5 to address 0x3C reloads every protected register from the current `dflt_in` and sets `dev_addr` to 0x00 on that edge. The bank is left disarmed.
- R7: A write of any value other than 0xA5 to address 0x3C changes no register.
- R8: A write to address 0x3B stores `wr_data` into `dev_addr` without an unlock.
- R9: `rd_data` shows the addressed register combinationally: 0x3B gives the device address, 0x40+i gives protected register i, and every other address, including 0x3A and 0x3C, gives 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (8) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| rd_addr | input | ADDR_W (8) | Read address |
| rd_data | output | DATA_W (8) | Read data for `rd_addr` |
| dflt_in | input | NUM_PROT*DATA_W (16) | Default values, byte i for protected register i |
| cfg_q | output | NUM_PROT*DATA_W (16) | Working protected registers, byte i for register i |
| dev_addr | output | DATA_W (8) | Device address register |

## Verification
On every cycle, the assertions check the following:
- an unarmed protected write leaves `cfg_q` steady;
- any write that is not the key leaves the bank disarmed;
- a software reset returns the registers to the sampled defaults and clears the address;
- idle registers stay steady.

Only the directed scenarios can show the full key-then-write ordering and its expected values. These include a re-armed key, an interrupted unlock, a non-key write to 0x3A, the ignored command value and read decoding. They also show that a default change after reset does not reach `cfg_q` until a reload.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
   localparam int unsigned BANK_ADDR_W   = 8;
   localparam int unsigned BANK_DATA_W   = 8;
   localparam int unsigned KEY_REG_ADDR  = 'h3A;
   localparam int unsigned KEY_VALUE     = 'h35;
   localparam int unsigned CMD_REG_ADDR  = 'h3C;
   localparam int unsigned CMD_RESET_VAL = 'hA5;
   localparam int unsigned DEVID_ADDR    = 'h3B;
   localparam int unsigned PROT_BASE     = 'h40;

   typedef enum logic {
      LOCKED = 1'b0,
      ARMED  = 1'b1
   } unlock_state_e;
endpackage

// File: rtl/cfg_unlock_tracker.sv
module cfg_unlock_tracker
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned KEY_ADR = 'h3A,
   parameter int unsigned KEY_VAL = 'h35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              armed
);
   localparam logic [ADDR_W-1:0] KEY_A = ADDR_W'(KEY_ADR);
   localparam logic [DATA_W-1:0] KEY_D = DATA_W'(KEY_VAL);

   unlock_state_e state_q;
   logic          key_hit;

   assign key_hit = wr_en && (wr_addr == KEY_A) && (wr_data == KEY_D);

   always_ff @(posedge clk) begin
      if (!rst_n)     state_q <= LOCKED;
      else if (wr_en) state_q <= key_hit ? ARMED : LOCKED;
   end

   assign armed = (state_q == ARMED);

   // R5: any non-key write leaves the bank disarmed
   p_disarm_on_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !(wr_addr == KEY_A && wr_data == KEY_D)) |=> !armed);
   // R3: a key write arms the bank
   p_arm_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == KEY_A && wr_data == KEY_D) |=> armed);
endmodule

// File: rtl/cfg_soft_reset_decode.sv
module cfg_soft_reset_decode #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned CMD_ADR    = 'h3C,
   parameter int unsigned CMD_VAL    = 'hA5,
   parameter bit          SRST_ENABLE = 1'b1
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              soft_rst
);
   localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADR);
   localparam logic [DATA_W-1:0] CMD_D = DATA_W'(CMD_VAL);

   generate
      if (SRST_ENABLE) begin : g_decode
         assign soft_rst = wr_en && (wr_addr == CMD_A) && (wr_data == CMD_D);
      end else begin : g_none
         assign soft_rst = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/cfg_shadow_slot.sv
module cfg_shadow_slot #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reload,
   input  logic              wr_accept,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] dflt,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n || reload) q <= dflt;
      else if (wr_accept)   q <= wr_data;
   end

   // R6: a reload takes the default present at that edge
   p_reload_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (q == $past(dflt)));
   // R2: with no reload and no accepted write, the working copy holds
   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!reload && !wr_accept) |=> $stable(q));
endmodule

// File: rtl/shadow_cfg_bank.sv
module shadow_cfg_bank
   import cfg_bank_pkg::*;
#(
   parameter int unsigned ADDR_W      = BANK_ADDR_W,
   parameter int unsigned DATA_W      = BANK_DATA_W,
   parameter int unsigned NUM_PROT    = 2,
   parameter int unsigned BASE_ADR    = PROT_BASE,
   parameter int unsigned DEV_ADR     = DEVID_ADDR,
   parameter int unsigned KEY_ADR     = KEY_REG_ADDR,
   parameter int unsigned KEY_VAL     = KEY_VALUE,
   parameter int unsigned CMD_ADR     = CMD_REG_ADDR,
   parameter int unsigned CMD_VAL     = CMD_RESET_VAL,
   parameter bit          SRST_ENABLE = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   input  logic [NUM_PROT*DATA_W-1:0]   dflt_in,
   output logic [NUM_PROT*DATA_W-1:0]   cfg_q,
   output logic [DATA_W-1:0]            dev_addr
);
   localparam int unsigned      TOP_ADR = BASE_ADR + NUM_PROT - 1;
   localparam logic [ADDR_W-1:0] DEV_A  = ADDR_W'(DEV_ADR);

   // elaboration-time parameter checks
   generate
      if (NUM_PROT < 1) begin : g_bad_count
         $error("NUM_PROT must be at least 1");
      end
      if (TOP_ADR >= (1 << ADDR_W)) begin : g_bad_range
         $error("protected range exceeds address space");
      end
      if ((KEY_ADR >= BASE_ADR && KEY_ADR <= TOP_ADR) ||
          (CMD_ADR >= BASE_ADR && CMD_ADR <= TOP_ADR) ||
          (DEV_ADR >= BASE_ADR && DEV_ADR <= TOP_ADR) ||
          KEY_ADR == CMD_ADR || KEY_ADR == DEV_ADR || CMD_ADR == DEV_ADR) begin : g_bad_map
         $error("register addresses overlap");
      end
   endgenerate

   logic                armed;
   logic                soft_rst;
   logic                prot_hit;
   logic [NUM_PROT-1:0] slot_hit;

   cfg_unlock_tracker #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W),
      .KEY_ADR(KEY_ADR), .KEY_VAL(KEY_VAL)
   ) i_unlock (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed)
   );

   cfg_soft_reset_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .CMD_ADR(CMD_ADR), .CMD_VAL(CMD_VAL), .SRST_ENABLE(SRST_ENABLE)
   ) i_srst (
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .soft_rst(soft_rst)
   );

   generate
      for (genvar i = 0; i < NUM_PROT; i++) begin : g_slot
         localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(BASE_ADR + i);
         assign slot_hit[i] = wr_en && (wr_addr == SLOT_A);
         cfg_shadow_slot #(.DATA_W(DATA_W)) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .reload   (soft_rst),
            .wr_accept(slot_hit[i] && armed),
            .wr_data  (wr_data),
            .dflt     (dflt_in[i*DATA_W +: DATA_W]),
            .q        (cfg_q[i*DATA_W +: DATA_W])
         );
      end
   endgenerate

   assign prot_hit = |slot_hit;

   cfg_shadow_slot #(.DATA_W(DATA_W)) i_devid (
      .clk      (clk),
      .rst_n    (rst_n),
      .reload   (soft_rst),
      .wr_accept(wr_en && (wr_addr == DEV_A)),
      .wr_data  (wr_data),
      .dflt     ('0),
      .q        (dev_addr)
   );

   always_comb begin
      rd_data = '0;
      if (rd_addr == DEV_A) rd_data = dev_addr;
      for (int k = 0; k < NUM_PROT; k++) begin
         if (rd_addr == ADDR_W'(BASE_ADR + k)) rd_data = cfg_q[k*DATA_W +: DATA_W];
      end
   end

   // R4: an unarmed protected write is dropped
   p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_hit && !armed) |=> $stable(cfg_q));
   // R6: the software reset command clears the device address
   p_srst_devaddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (dev_addr == '0));
   // R6: after a software reset the bank is disarmed
   p_srst_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !armed);
endmodule

// File: tb/test_shadow_cfg_bank.sv
module test_shadow_cfg_bank;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NP = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [7:0]    wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [7:0]    rd_addr = '0;
   logic [7:0]    rd_data;
   logic [15:0]   dflt_in = 16'h0C50;
   logic [15:0]   cfg_q;
   logic [7:0]    dev_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   shadow_cfg_bank #(.NUM_PROT(NP)) i_shadow_cfg_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .dflt_in(dflt_in), .cfg_q(cfg_q), .dev_addr(dev_addr)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      chk("R1 cfg after reset", cfg_q, 32'h0C50);
      chk("R1 dev_addr after reset", dev_addr, 0);
      rd_chk("R1 read 0x40", 8'h40, 8'h50);
   endtask

   task automatic t_default_isolated();
      dflt_in = 16'hBEEF;
      repeat (3) @(negedge clk);
      chk("R2 cfg ignores dflt change", cfg_q, 32'h0C50);
   endtask

   task automatic t_locked_write();
      wr(8'h40, 8'h77);
      chk("R4 locked write dropped", cfg_q, 32'h0C50);
   endtask

   task automatic t_unlocked_write();
      wr(8'h3A, 8'h35);
      wr(8'h40, 8'h77);
      chk("R3 unlocked write accepted", cfg_q, 32'h0C77);
      wr(8'h40, 8'h11);
      chk("R5 unlock consumed", cfg_q, 32'h0C77);
      wr(8'h3A, 8'h35);
      wr(8'h3A, 8'h35);
      wr(8'h41, 8'h22);
      chk("R3 re-key keeps armed", cfg_q, 32'h2277);
   endtask

   task automatic t_interrupted();
      wr(8'h3A, 8'h35);
      wr(8'h3B, 8'h05);
      wr(8'h41, 8'h99);
      chk("R5 intervening write cancels", cfg_q, 32'h2277);
      chk("R8 dev_addr written", dev_addr, 8'h05);
      wr(8'h3A, 8'h35);
      wr(8'h3A, 8'h12);
      wr(8'h41, 8'h99);
      chk("R5 non-key to 0x3A disarms", cfg_q, 32'h2277);
   endtask

   task automatic t_cmd_other();
      wr(8'h3C, 8'h5A);
      chk("R7 non-magic cmd cfg", cfg_q, 32'h2277);
      chk("R7 non-magic cmd dev_addr", dev_addr, 8'h05);
   endtask

   task automatic t_soft_reset();
      wr(8'h3A, 8'h35);
      wr(8'h3C, 8'hA5);
      chk("R6 soft reset reloads defaults", cfg_q, 32'hBEEF);
      chk("R6 soft reset clears dev_addr", dev_addr, 0);
      wr(8'h40, 8'h33);
      chk("R6 disarmed after soft reset", cfg_q, 32'hBEEF);
   endtask

   task automatic t_reads();
      wr(8'h3B, 8'h2A);
      rd_chk("R9 read dev_addr", 8'h3B, 8'h2A);
      rd_chk("R9 read 0x41", 8'h41, 8'hBE);
      rd_chk("R9 read key reg", 8'h3A, 8'h00);
      rd_chk("R9 read cmd reg", 8'h3C, 8'h00);
      rd_chk("R9 read unmapped", 8'h10, 8'h00);
      rd_chk("R9 read past range", 8'h42, 8'h00);
   endtask

   task automatic t_hw_reset_again();
      wr(8'h3A, 8'h35);
      wr(8'h40, 8'h01);
      chk("R3 write before hw reset", cfg_q, 32'hBE01);
      dflt_in = 16'h0C50;
      t_reset();
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_default_isolated();
            t_locked_write();
            t_unlocked_write();
            t_interrupted();
            t_cmd_other();
            t_soft_reset();
            t_reads();
            t_hw_reset_again();
            done = 1'b1;
         end
         begin
            repeat (5000) @(posedge clk);
         end
      join_any
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=complete");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule